// File: doc/BRIEF.md
# Strobed FIFO with Retransmit

A first-in first-out buffer holding 1024 words of 9 bits. Writes and reads are single-cycle strobes sampled on one clock; two internal pointers generate the storage addresses, so the user never supplies an address. All nine bits are ordinary payload and leave the buffer in the order they arrived.

Status outputs show when the buffer is empty, full, or more than half full. Requests that would overwrite stored data or read a missing word are ignored. A retransmit strobe rewinds the read side to the first storage location and leaves the write side alone. A sender can therefore replay a block after an error is detected, provided fewer than 1024 words have been written since reset.

Top module: `strobe_fifo`

## Requirements
- R1: All 9 bits of each stored word, including bit 8, are returned unchanged.
- R2: Each accepted write advances the write position by one. Each accepted read advances the read position by one. Words are read out in the order they were written.
- R3: A write strobe while full_o is high is ignored. No stored word is overwritten and full_o stays high.
- R4: A read strobe while empty_o is high is ignored. rdata_o holds its value and empty_o stays high.
- R5: A retransmit strobe sets the read position to address zero and leaves the write position unchanged. The occupancy becomes the number of words written since reset. The next reads return the words from the first one written.
- R6: When a retransmit and a read are strobed in the same cycle, the retransmit wins, the read is ignored, and rdata_o holds its value.
- R7: empty_o is high exactly when 0 words are stored. full_o is high exactly when 1024 words are stored.
- R8: half_o is high exactly when 513 or more words are stored.
- R9: A write and a read strobed together while neither empty nor full are both accepted, and the occupancy does not change.
- R10: Reset (rst_ni low) clears both positions and the occupancy. After reset, empty_o=1, full_o=0, half_o=0 and rdata_o=0.
- R11: The word from an accepted read appears on rdata_o after the next rising clock edge. rdata_o holds its value in every cycle without an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 9 | Write data |
| rd_i | input | 1 | Read strobe |
| rtx_i | input | 1 | Retransmit strobe |
| rdata_o | output | 9 | Registered read data |
| empty_o | output | 1 | No words stored |
| full_o | output | 1 | 1024 words stored |
| half_o | output | 1 | 513 or more words stored |

## Verification
The hardest conditions to reach are the occupancy edges: the step from 512 to 513 words and a write attempt against a completely full buffer. The bench reaches them by writing more than a thousand words in sequence and checking the flags after every strobe. It then drains the whole buffer to show that the rejected write corrupted nothing. Retransmit is exercised after a partial drain, including the cycle where it collides with a read. A bench-side queue model replays the whole history from the first word.

// File: rtl/strobe_fifo_pkg.sv
package strobe_fifo_pkg;
  typedef struct packed {
    logic empty;
    logic full;
    logic half;
  } fifo_flags_t;
endpackage

// File: rtl/fifo_mem.sv
module fifo_mem #(
  parameter int unsigned DW    = 9,
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= mem_q[raddr_i];
  end

  p_rdata_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
endmodule

// File: rtl/fifo_ptr_ctrl.sv
module fifo_ptr_ctrl
  import strobe_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic          rtx_i,
  output logic          wr_en_o,
  output logic          rd_en_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [AW-1:0] rd_addr_o,
  output fifo_flags_t   flags_o
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] count_q;

  always_comb begin
    flags_o.empty = (count_q == '0);
    flags_o.full  = (count_q == FULL_CNT);
    flags_o.half  = (count_q > HALF_CNT);
    wr_en_o = wr_i && !flags_o.full;
    // retransmit takes priority over a same-cycle read
    rd_en_o = rd_i && !flags_o.empty && !rtx_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (wr_en_o) wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
      if (rtx_i) begin
        rd_ptr_q <= '0;
        count_q  <= CW'(wr_ptr_q) + CW'(wr_en_o);
      end else begin
        if (rd_en_o) rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
        case ({wr_en_o, rd_en_o})
          2'b10:   count_q <= count_q + 1'b1;
          2'b01:   count_q <= count_q - 1'b1;
          default: count_q <= count_q;
        endcase
      end
    end
  end

  assign wr_addr_o = wr_ptr_q;
  assign rd_addr_o = rd_ptr_q;

  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o.full && wr_i && !rd_i && !rtx_i) |=> ($stable(wr_ptr_q) && flags_o.full));

  p_no_underflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags_o.empty && rd_i && !wr_i && !rtx_i) |=> ($stable(rd_ptr_q) && flags_o.empty));

  p_rtx_rewind_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rtx_i && !wr_i) |=> (rd_ptr_q == '0 && $stable(wr_ptr_q)));

  p_rw_balance_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && rd_i && !rtx_i && !flags_o.empty && !flags_o.full) |=> $stable(count_q));

  p_count_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= FULL_CNT);
endmodule

// File: rtl/strobe_fifo.sv
module strobe_fifo
  import strobe_fifo_pkg::*;
#(
  parameter int unsigned DW    = 9,
  parameter int unsigned DEPTH = 1024,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  input  logic          rtx_i,
  output logic [DW-1:0] rdata_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          half_o
);
  logic          wr_en, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;
  fifo_flags_t   flags;

  fifo_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .wr_i, .rd_i, .rtx_i,
    .wr_en_o(wr_en), .rd_en_o(rd_en),
    .wr_addr_o(wr_addr), .rd_addr_o(rd_addr),
    .flags_o(flags)
  );

  fifo_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk_i, .rst_ni,
    .we_i(wr_en), .waddr_i(wr_addr), .wdata_i,
    .re_i(rd_en), .raddr_i(rd_addr), .rdata_o
  );

  assign empty_o = flags.empty;
  assign full_o  = flags.full;
  assign half_o  = flags.half;
endmodule

// File: tb/strobe_fifo_tb_top.sv
module strobe_fifo_tb_top;
  localparam int DEPTH = 1024;

  logic clk = 0, rst_ni = 0;
  logic wr_i = 0, rd_i = 0, rtx_i = 0;
  logic [8:0] wdata_i = '0;
  logic [8:0] rdata_o;
  logic empty_o, full_o, half_o;

  int n_run = 0, n_fail = 0;
  logic [8:0] q[$];
  logic [8:0] hist[$];
  logic [8:0] exp_rd;

  always #5 clk = ~clk;

  strobe_fifo dut_i (.clk_i(clk), .rst_ni, .wr_i, .wdata_i, .rd_i, .rtx_i,
                     .rdata_o, .empty_o, .full_o, .half_o);

  function automatic logic [8:0] pat(int k);
    return 9'((k * 37 + 5) & 9'h1FF);
  endfunction

  task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 0; wr_i = 0; rd_i = 0; rtx_i = 0;
    @(negedge clk);
    rst_ni = 1;
    q.delete(); hist.delete(); exp_rd = '0;
  endtask

  // one strobe cycle; model update, then checks at next falling edge
  task automatic step(bit w, logic [8:0] d, bit r, bit x);
    int cnt = q.size();
    bit wok = w && cnt < DEPTH;
    bit rok = r && cnt > 0 && !x;
    wr_i = w; wdata_i = d; rd_i = r; rtx_i = x;
    if (x) q = hist;
    if (rok) exp_rd = q.pop_front();
    if (wok) begin q.push_back(d); hist.push_back(d); end
    @(negedge clk);
    wr_i = 0; rd_i = 0; rtx_i = 0;
    chk("R11 rdata", rdata_o, exp_rd);
    chk("R7 empty", 9'(empty_o), 9'(q.size() == 0));
    chk("R7 full", 9'(full_o), 9'(q.size() == DEPTH));
    chk("R8 half", 9'(half_o), 9'(q.size() > DEPTH / 2));
  endtask

  task automatic t_reset();
    do_reset();
    chk("R10 empty", 9'(empty_o), 9'd1);
    chk("R10 full", 9'(full_o), 9'd0);
    chk("R10 half", 9'(half_o), 9'd0);
    chk("R10 rdata", rdata_o, 9'd0);
  endtask

  task automatic t_underflow();
    do_reset();
    step(1, 9'h1A5, 0, 0);
    step(0, 0, 1, 0);
    chk("R4 first read", rdata_o, 9'h1A5);
    step(0, 0, 1, 0);
    chk("R4 read on empty holds", rdata_o, 9'h1A5);
    chk("R4 still empty", 9'(empty_o), 9'd1);
  endtask

  task automatic t_order();
    do_reset();
    step(1, 9'h100, 0, 0);
    step(1, 9'h0FF, 0, 0);
    step(1, 9'h155, 0, 0);
    step(0, 0, 1, 0);
    chk("R1 bit8 kept", rdata_o, 9'h100);
    step(0, 0, 1, 0);
    chk("R2 order", rdata_o, 9'h0FF);
    step(0, 0, 0, 0);
    chk("R11 hold without read", rdata_o, 9'h0FF);
    step(0, 0, 1, 0);
    chk("R2 order last", rdata_o, 9'h155);
  endtask

  task automatic t_rw();
    do_reset();
    step(1, 9'h011, 0, 0);
    step(1, 9'h022, 1, 0);
    chk("R9 read with write", rdata_o, 9'h011);
    step(1, 9'h033, 1, 0);
    chk("R9 second", rdata_o, 9'h022);
    chk("R9 count kept", 9'(empty_o), 9'd0);
    step(0, 0, 1, 0);
    chk("R9 tail", rdata_o, 9'h033);
    chk("R9 drained", 9'(empty_o), 9'd1);
  endtask

  task automatic t_fill();
    do_reset();
    for (int k = 0; k < DEPTH / 2; k++) step(1, pat(k), 0, 0);
    chk("R8 at 512", 9'(half_o), 9'd0);
    step(1, pat(DEPTH / 2), 0, 0);
    chk("R8 at 513", 9'(half_o), 9'd1);
    for (int k = DEPTH / 2 + 1; k < DEPTH; k++) step(1, pat(k), 0, 0);
    chk("R7 full at 1024", 9'(full_o), 9'd1);
    step(1, 9'h1FF, 0, 0);
    chk("R3 full held", 9'(full_o), 9'd1);
    for (int k = 0; k < DEPTH; k++) begin
      step(0, 0, 1, 0);
      chk("R3 no overwrite", rdata_o, pat(k));
    end
    chk("R7 empty after drain", 9'(empty_o), 9'd1);
  endtask

  task automatic t_rtx();
    do_reset();
    for (int k = 0; k < 10; k++) step(1, pat(k + 100), 0, 0);
    for (int k = 0; k < 4; k++) step(0, 0, 1, 0);
    chk("R5 pre", rdata_o, pat(103));
    step(0, 0, 1, 1);
    chk("R6 read ignored on rtx", rdata_o, pat(103));
    step(0, 0, 1, 0);
    chk("R5 replay first", rdata_o, pat(100));
    for (int k = 1; k < 10; k++) step(0, 0, 1, 0);
    chk("R5 replay last", rdata_o, pat(109));
    chk("R5 occupancy", 9'(empty_o), 9'd1);
    step(1, 9'h0AB, 0, 0);
    step(0, 0, 1, 0);
    chk("R5 write side kept", rdata_o, 9'h0AB);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_underflow();
    t_order();
    t_rw();
    t_fill();
    t_rtx();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule